// File: doc/BRIEF.md
# Dual-Word Numerically Controlled Oscillator

This block is a numerically controlled oscillator core. A 32-bit phase register wraps once per output cycle and advances on every clock by a tuning word, so the output frequency is word × f_clk / 2^32. With a 50 MHz clock a word of 1 gives a step of about 0.0116 Hz.

The block holds two tuning words, A and B. A select pin picks the one that drives the phase register, and the choice can change on any cycle without disturbing the phase. This lets a controller keep a second frequency ready and swap to it at once, for example to transmit and receive on different frequencies. Both words are written over a three-wire serial port (data, shift clock, load strobe) plus a destination pin. The serial pins may be asynchronous to the core clock and are synchronised inside.

The ten most significant phase bits address a 256-entry quarter-wave magnitude table. Quadrant logic mirrors and negates that table to rebuild a full signed 12-bit sine.

Top module: `nco_dual_word`

## Requirements
- R1: On each clock with reset low, `phase_out` advances by the selected tuning word modulo 2^32. For example, a word of 2^22 returns the phase to its starting value after exactly 1024 clocks.
- R2: `fsel` = 0 selects word A and `fsel` = 1 selects word B. A change of `fsel` sets the very next phase step, and the phase is not cleared by it.
- R3: On each rising edge of `ser_clk`, the level of `ser_data` is shifted into a 32-bit register, most significant bit first. When more than 32 bits are shifted, only the last 32 are kept.
- R4: A rising edge of `ser_load` copies the shift register into word A when `ser_dest` = 0, or into word B when `ser_dest` = 1. The other word is unchanged. Shifting without a load strobe changes neither word.
- R5: `sine_out` is a two's-complement value that lags `phase_out` by one clock. For the top ten phase bits p, it equals round(2047·sin(2π(p+0.5)/1024)) within 1 LSB, and it never takes the value -2048.
- R6: The sine samples are exactly symmetric: s(p+512) = -s(p) and s(511-p) = s(p).
- R7: A synchronous reset clears the phase, both tuning words, the shift register and `sine_out` to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous reset, active high |
| ser_clk | input | 1 | Serial shift clock, rising edge active |
| ser_data | input | 1 | Serial data, most significant bit first |
| ser_load | input | 1 | Load strobe, rising edge copies the shifted word |
| ser_dest | input | 1 | Destination of the load: 0 = word A, 1 = word B |
| fsel | input | 1 | Active word select: 0 = A, 1 = B |
| phase_out | output | 32 | Phase register value |
| sine_out | output | 12 | Signed sine sample |

## Verification
A phase step appears at `phase_out` one clock after the edge that applies it. The sample for that phase appears on `sine_out` one clock later still. The bench therefore samples both outputs on the falling edge, takes the difference between consecutive phase samples, and checks each sine sample against the phase it read one sample earlier. The serial pins pass through two synchroniser flops and an edge detector, so every serial level is held for four clocks. The bench then waits several more clocks after a load before it measures the new step. A full sweep of all 1024 table positions checks both the absolute error and the exact mirror and negation relations.

// File: rtl/nco_dual_word.sv
module nco_dual_word #(
  parameter int ACC_W = 32,
  parameter int IDX_W = 10,
  parameter int AMP_W = 12
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    ser_clk,
  input  logic                    ser_data,
  input  logic                    ser_load,
  input  logic                    ser_dest,
  input  logic                    fsel,
  output logic [ACC_W-1:0]        phase_out,
  output logic signed [AMP_W-1:0] sine_out
);
  localparam int QW    = IDX_W - 2;
  localparam int QN    = 1 << QW;
  localparam int MAG_W = AMP_W - 1;
  localparam real AMAX = real'((1 << MAG_W) - 1);

  function automatic logic [MAG_W-1:0] qsin(input int i);
    real x, t, s;
    x = 1.5707963267948966 * (real'(i) + 0.5) / real'(QN);
    s = x;
    t = x;
    for (int k = 1; k < 9; k++) begin
      t = -t * x * x / real'((2 * k) * (2 * k + 1));
      s = s + t;
    end
    return MAG_W'($rtoi(s * AMAX + 0.5));
  endfunction

  logic [2:0] ck_q, ld_q;
  logic [1:0] dt_q, ds_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ck_q <= '0;
      ld_q <= '0;
      dt_q <= '0;
      ds_q <= '0;
    end else begin
      ck_q <= {ck_q[1:0], ser_clk};
      ld_q <= {ld_q[1:0], ser_load};
      dt_q <= {dt_q[0], ser_data};
      ds_q <= {ds_q[0], ser_dest};
    end
  end

  wire ck_rise = ck_q[1] & ~ck_q[2];
  wire ld_rise = ld_q[1] & ~ld_q[2];

  logic [ACC_W-1:0] shreg, word_a, word_b, acc;

  always_ff @(posedge clk) begin
    if (rst)          shreg <= '0;
    else if (ck_rise) shreg <= {shreg[ACC_W-2:0], dt_q[1]};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      word_a <= '0;
      word_b <= '0;
    end else if (ld_rise) begin
      if (ds_q[1]) word_b <= shreg;
      else         word_a <= shreg;
    end
  end

  wire [ACC_W-1:0] step = fsel ? word_b : word_a;

  always_ff @(posedge clk) begin
    if (rst) acc <= '0;
    else     acc <= acc + step;
  end

  wire [IDX_W-1:0] pidx = acc[ACC_W-1 -: IDX_W];
  wire [1:0]       quad = pidx[IDX_W-1 -: 2];
  wire [QW-1:0]    fine = pidx[QW-1:0];
  wire [QW-1:0]    addr = quad[0] ? ~fine : fine;

  logic [MAG_W-1:0] qtab [QN];
  for (genvar g = 0; g < QN; g++) begin : g_rom
    assign qtab[g] = qsin(g);
  end

  wire [MAG_W-1:0]        mag  = qtab[addr];
  wire signed [AMP_W-1:0] pos  = $signed({1'b0, mag});
  wire signed [AMP_W-1:0] sval = quad[1] ? -pos : pos;

  logic signed [AMP_W-1:0] sine_q;
  always_ff @(posedge clk) begin
    if (rst) sine_q <= '0;
    else     sine_q <= sval;
  end

  assign phase_out = acc;
  assign sine_out  = sine_q;

  assert_step_R1: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> acc == $past(acc) + ($past(fsel) ? $past(word_b) : $past(word_a)));

  assert_shift_in_R3: assert property (@(posedge clk) disable iff (rst)
    ck_rise |=> shreg == {$past(shreg[ACC_W-2:0]), $past(dt_q[1])});

  assert_words_hold_R4: assert property (@(posedge clk) disable iff (rst)
    !ld_rise |=> $stable(word_a) && $stable(word_b));

  assert_load_a_R4: assert property (@(posedge clk) disable iff (rst)
    ld_rise && !ds_q[1] |=> word_a == $past(shreg) && $stable(word_b));

  assert_load_b_R4: assert property (@(posedge clk) disable iff (rst)
    ld_rise && ds_q[1] |=> word_b == $past(shreg) && $stable(word_a));

  assert_no_min_code_R5: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> sine_out != {1'b1, {MAG_W{1'b0}}});

  assert_reset_clear_R7: assert property (@(posedge clk)
    rst |=> acc == '0 && word_a == '0 && word_b == '0 && sine_q == '0);
endmodule

// File: tb/tb_nco_dual_word.sv
module tb_nco_dual_word;
  logic clk = 0;
  always #10 clk = ~clk;

  logic rst = 1, ser_clk = 0, ser_data = 0, ser_load = 0, ser_dest = 0, fsel = 0;
  logic [31:0] phase_out;
  logic signed [11:0] sine_out;

  nco_dual_word dut (.clk, .rst, .ser_clk, .ser_data, .ser_load, .ser_dest, .fsel,
                     .phase_out, .sine_out);

  int vec = 0, bad = 0;
  logic signed [11:0] tab [1024];

  task automatic chk(bit ok, string req, longint act, longint exp);
    vec++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic shift_bits(logic [63:0] bits, int n);
    for (int i = n - 1; i >= 0; i--) begin
      ser_data = bits[i];
      cyc(4);
      ser_clk = 1;
      cyc(4);
      ser_clk = 0;
    end
    cyc(4);
  endtask

  task automatic send(logic [63:0] bits, int n, bit dest);
    shift_bits(bits, n);
    ser_dest = dest;
    cyc(4);
    ser_load = 1;
    cyc(4);
    ser_load = 0;
    cyc(6);
  endtask

  task automatic step_check(logic [31:0] exp, int n, string req);
    logic [31:0] prev;
    prev = phase_out;
    for (int i = 0; i < n; i++) begin
      cyc(1);
      chk(phase_out - prev == exp, req, phase_out - prev, exp);
      prev = phase_out;
    end
  endtask

  function automatic int exp_sine(int p);
    real v;
    v = 2047.0 * $sin(2.0 * 3.141592653589793 * (real'(p) + 0.5) / 1024.0);
    return (v >= 0.0) ? $rtoi(v + 0.5) : -$rtoi(-v + 0.5);
  endfunction

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
    $finish;
  endtask

  initial begin
    #(20 * 150000);
    chk(0, "watchdog", 0, 1);
    finish_run();
  end

  initial begin
    logic [31:0] prev, ph;
    int p, e;
    cyc(3);
    chk(phase_out == 0, "R7 reset phase", phase_out, 0);
    chk(sine_out == 0, "R7 reset sine", sine_out, 0);
    rst = 0;
    step_check(0, 5, "R7 words zero after reset");

    send(64'h400000, 32, 0);
    step_check(32'h400000, 20, "R1 step A");

    prev = phase_out;
    for (int i = 0; i < 1030; i++) begin
      cyc(1);
      p = int'(prev[31:22]);
      e = exp_sine(p);
      chk((int'(sine_out) - e <= 1) && (e - int'(sine_out) <= 1), "R5 sine value", sine_out, e);
      tab[p] = sine_out;
      prev = phase_out;
    end
    for (int i = 0; i < 512; i++)
      chk(tab[i + 512] == -tab[i], "R6 half-cycle negation", tab[i + 512], -tab[i]);
    for (int i = 0; i < 256; i++)
      chk(tab[511 - i] == tab[i], "R6 quarter mirror", tab[511 - i], tab[i]);

    ph = phase_out;
    cyc(1024);
    chk(phase_out == ph, "R1 period 1024", phase_out, ph);

    send(64'hFFFF_FFFF, 32, 1);
    step_check(32'h400000, 8, "R4 load B leaves A");

    prev = phase_out;
    fsel = 1;
    cyc(1);
    chk(phase_out == prev - 1, "R2 switch next edge, phase kept", phase_out, prev - 1);
    step_check(32'hFFFF_FFFF, 5, "R2 step B");
    fsel = 0;
    step_check(32'h400000, 5, "R2 back to A");

    send({8'hA5, 24'h0, 32'h0001_2345}, 64, 0);
    step_check(32'h12345, 10, "R3 msb first, last 32 kept");

    shift_bits(64'hDEAD_BEEF, 32);
    step_check(32'h12345, 10, "R4 shift without load A");
    fsel = 1;
    step_check(32'hFFFF_FFFF, 3, "R4 shift without load B");
    fsel = 0;

    send(64'h8000_0001, 32, 0);
    step_check(32'h8000_0001, 16, "R1 wrap");

    rst = 1;
    cyc(2);
    chk(phase_out == 0, "R7 mid reset phase", phase_out, 0);
    chk(sine_out == 0, "R7 mid reset sine", sine_out, 0);
    rst = 0;
    step_check(0, 4, "R7 word A cleared");
    fsel = 1;
    step_check(0, 4, "R7 word B cleared");

    finish_run();
  end
endmodule